// File: doc/BRIEF.md
# Optical Link Liveness and Integrity Monitor

This block sits beside one optical transmitter/receiver pair. It watches that channel for silence and for corruption. On the send side it forwards fixed-length packets from an upstream source one flit per handshake and appends a 16-bit CRC trailer to each packet. When nothing has been sent for a programmed number of cycles, it inserts a hello word that carries a fixed pattern. The same pairing can serve a board's home-channel monitor.

On the receive side it recomputes the CRC of each incoming packet and compares the pattern of each incoming hello. A watchdog restarts whenever any word arrives. It catches a channel that dies during a quiet period, because the far end is obliged to send hellos. A received error-notification word, which reports that the far end has found a fault, is passed on at once.

The first problem found latches a sticky fault flag and a one-hot cause. It also raises a one-cycle request for an error packet toward the transmitters. While the flag is set, the channel is shut: no new data is accepted and nothing is sent. Software clears the flag. Transmit and receive state machines are named below. Transmit: TX_IDLE, TX_DATA, TX_TRAIL, TX_HELLO, TX_DOWN. Receive: RX_IDLE, RX_BODY, RX_TRAIL.

Top module: `lhm_link_monitor`

## Requirements
- R1: After reset, `fault` is 0, `fault_cause` is 0, `lk_tx_valid` is 0 and `up_ready` is 1.
- R2: Each accepted upstream flit appears on the link one cycle later with kind code 0 (data), in acceptance order. After PKT_FLITS data words, exactly one trailer word follows.
- R3: The trailer word has kind code 1. Its low 16 bits hold the CRC of the packet and its upper bits are zero. The CRC uses polynomial 0x1021 and initial value 0xFFFF, with no final XOR. Each flit is fed most significant bit first. A received packet whose trailer matches raises no fault.
- R4: With the link healthy and no data offered, a hello word is sent, with kind code 2 and word equal to HELLO_PAT. It goes out exactly `cfg_idle`+1 cycles after the previous trailer or hello word.
- R5: Suppose an upstream request arrives in the very cycle the idle count expires. The data flit is sent, and no hello precedes it.
- R6: Every received word restarts the receive watchdog. After `cfg_timeout` consecutive cycles with no received word, `fault` rises in the next cycle with cause bit 0 (timeout). Continuous hello traffic never trips it.
- R7: A received hello (kind 2) whose word differs from HELLO_PAT sets `fault` with cause bit 1.
- R8: A trailer whose low 16 bits differ from the recomputed CRC sets `fault` with cause bit 2. So does a trailer that arrives before PKT_FLITS data words.
- R9: A received kind 3 word (error notification) gives a one-cycle `peer_err_seen` pulse in the next cycle and sets `fault` with cause bit 3.
- R10: `fault` is sticky. `fault_cause` holds exactly one bit, the first cause seen, unchanged by later events. `err_pkt_req` pulses for one cycle, together with the rise of `fault`.
- R11: While `fault` is set, `up_ready` is 0. From the second cycle of the fault on, no link word is sent.
- R12: A `fault_clr` pulse clears `fault` and `fault_cause` in the next cycle. `up_ready` returns one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idle | input | IDLE_W | Idle cycles before a hello is inserted |
| cfg_timeout | input | TMO_W | Silent receive cycles that count as a fault |
| fault_clr | input | 1 | Clears the sticky fault and its cause |
| up_valid | input | 1 | Upstream flit offered |
| up_ready | output | 1 | Upstream flit accepted this cycle |
| up_data | input | 64 | Upstream flit |
| lk_tx_valid | output | 1 | Link transmit word valid |
| lk_tx_kind | output | 2 | 0 data, 1 trailer, 2 hello, 3 error notification |
| lk_tx_word | output | 64 | Link transmit word |
| lk_rx_valid | input | 1 | Link receive word valid |
| lk_rx_kind | input | 2 | Kind of received word, same codes |
| lk_rx_word | input | 64 | Received word |
| fault | output | 1 | Sticky channel fault |
| fault_cause | output | 4 | One-hot first cause: 0 timeout, 1 hello, 2 CRC, 3 peer |
| err_pkt_req | output | 1 | One-cycle request for an error packet |
| peer_err_seen | output | 1 | Error notification received, toward routing and peer transmitter |

## Verification
Two transmit functions can fall in the same cycle: hello insertion and data acceptance. Both can act in the single cycle in which the idle count expires. The bench waits for a hello to appear and counts exactly `cfg_idle`-1 further cycles. It then offers a packet so that the handshake lands on the expiry edge. The scoreboard flags any hello seen before that packet's first data word. All other words on the link are compared against an ordered queue of expected data and trailer words.

// File: rtl/lhm_pkg.sv
package lhm_pkg;
    localparam int FLIT_W   = 64;
    localparam int CRC_W    = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
    localparam int CAUSE_W  = 4;
    localparam int C_TMO    = 0;
    localparam int C_HELLO  = 1;
    localparam int C_CRC    = 2;
    localparam int C_PEER   = 3;

    typedef enum logic [1:0] {K_DATA = 2'd0, K_TRAIL = 2'd1, K_HELLO = 2'd2, K_ERR = 2'd3} lk_kind_e;
    typedef enum logic [2:0] {TX_IDLE, TX_DATA, TX_TRAIL, TX_HELLO, TX_DOWN} tx_st_e;
    typedef enum logic [1:0] {RX_IDLE, RX_BODY, RX_TRAIL} rx_st_e;

    // serial CRC update over one flit, most significant bit first
    function automatic logic [CRC_W-1:0] crc_flit(input logic [CRC_W-1:0] seed,
                                                  input logic [FLIT_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = seed;
        for (int i = FLIT_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/lhm_tx_fsm.sv
module lhm_tx_fsm
    import lhm_pkg::*;
#(
    parameter int PKT_FLITS = 8,
    parameter int IDLE_W    = 16,
    parameter logic [FLIT_W-1:0] HELLO_PAT = 64'hA5C3_5A3C_0FF0_F00F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic [IDLE_W-1:0] cfg_idle,
    input  logic              up_valid,
    input  logic [FLIT_W-1:0] up_data,
    output logic              up_ready,
    output logic              tx_valid,
    output lk_kind_e          tx_kind,
    output logic [FLIT_W-1:0] tx_word
);
    localparam int CNT_W = $clog2(PKT_FLITS + 1);

    tx_st_e            st, nx;
    logic [IDLE_W-1:0] idle_cnt;
    logic [CNT_W-1:0]  flit_cnt;
    logic [CRC_W-1:0]  crc;
    logic              acc, idle_done;

    always_comb begin
        up_ready  = !fault && (st == TX_IDLE || st == TX_DATA);
        acc       = up_valid && up_ready;
        idle_done = ({1'b0, idle_cnt} + (IDLE_W+1)'(1)) >= {1'b0, cfg_idle};
    end

    always_comb begin
        nx = st;
        unique case (st)
            TX_IDLE: begin
                if (fault)          nx = TX_DOWN;
                else if (acc)       nx = (PKT_FLITS == 1) ? TX_TRAIL : TX_DATA;
                else if (idle_done) nx = TX_HELLO;
            end
            TX_DATA: begin
                if (fault) nx = TX_DOWN;
                else if (acc && flit_cnt == CNT_W'(PKT_FLITS - 1)) nx = TX_TRAIL;
            end
            TX_TRAIL: nx = fault ? TX_DOWN : TX_IDLE;
            TX_HELLO: nx = fault ? TX_DOWN : TX_IDLE;
            TX_DOWN:  if (!fault) nx = TX_IDLE;
            default:  nx = TX_DOWN;
        endcase
    end

    // state register with its counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= TX_IDLE;
            idle_cnt <= '0;
            flit_cnt <= '0;
            crc      <= CRC_INIT;
        end else begin
            st <= nx;
            if (st == TX_IDLE && nx == TX_IDLE) idle_cnt <= idle_cnt + 1'b1;
            else                                idle_cnt <= '0;
            if (acc) begin
                flit_cnt <= (st == TX_IDLE) ? CNT_W'(1) : flit_cnt + 1'b1;
                crc      <= crc_flit((st == TX_IDLE) ? CRC_INIT : crc, up_data);
            end
        end
    end

    // registered link outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_kind  <= K_DATA;
            tx_word  <= '0;
        end else begin
            tx_valid <= 1'b0;
            if (acc) begin
                tx_valid <= 1'b1;
                tx_kind  <= K_DATA;
                tx_word  <= up_data;
            end else if (st == TX_TRAIL && !fault) begin
                tx_valid <= 1'b1;
                tx_kind  <= K_TRAIL;
                tx_word  <= {{(FLIT_W-CRC_W){1'b0}}, crc};
            end else if (st == TX_HELLO && !fault) begin
                tx_valid <= 1'b1;
                tx_kind  <= K_HELLO;
                tx_word  <= HELLO_PAT;
            end
        end
    end
endmodule

// File: rtl/lhm_rx_fsm.sv
module lhm_rx_fsm
    import lhm_pkg::*;
#(
    parameter int PKT_FLITS = 8,
    parameter int TMO_W     = 20,
    parameter logic [FLIT_W-1:0] HELLO_PAT = 64'hA5C3_5A3C_0FF0_F00F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              rx_valid,
    input  lk_kind_e          rx_kind,
    input  logic [FLIT_W-1:0] rx_word,
    output logic              ev_tmo,
    output logic              ev_hello_bad,
    output logic              ev_crc_bad,
    output logic              ev_peer
);
    localparam int CNT_W = $clog2(PKT_FLITS + 1);

    rx_st_e           st, nx;
    logic [CNT_W-1:0] cnt;
    logic [CRC_W-1:0] crc, crc_nx;
    logic [TMO_W-1:0] tmo_cnt;
    logic             data_in, trail_in;

    always_comb begin
        data_in      = rx_valid && rx_kind == K_DATA;
        trail_in     = rx_valid && rx_kind == K_TRAIL;
        ev_hello_bad = rx_valid && rx_kind == K_HELLO && rx_word != HELLO_PAT;
        ev_peer      = rx_valid && rx_kind == K_ERR;
        ev_tmo       = !hold && !rx_valid &&
                       ({1'b0, tmo_cnt} + (TMO_W+1)'(1)) >= {1'b0, cfg_timeout};
        crc_nx       = crc_flit((st == RX_IDLE) ? CRC_INIT : crc, rx_word);
    end

    always_comb begin
        nx         = st;
        ev_crc_bad = 1'b0;
        unique case (st)
            RX_IDLE: begin
                if (trail_in)     ev_crc_bad = 1'b1;
                else if (data_in) nx = (PKT_FLITS == 1) ? RX_TRAIL : RX_BODY;
            end
            RX_BODY: begin
                if (trail_in) begin
                    ev_crc_bad = 1'b1;
                    nx         = RX_IDLE;
                end else if (data_in && cnt == CNT_W'(PKT_FLITS - 1)) begin
                    nx = RX_TRAIL;
                end
            end
            RX_TRAIL: begin
                if (data_in || trail_in) begin
                    nx         = RX_IDLE;
                    ev_crc_bad = data_in || (rx_word[CRC_W-1:0] != crc);
                end
            end
            default: nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            cnt     <= '0;
            crc     <= CRC_INIT;
            tmo_cnt <= '0;
        end else begin
            st <= nx;
            if (data_in && st != RX_TRAIL) begin
                cnt <= (st == RX_IDLE) ? CNT_W'(1) : cnt + 1'b1;
                crc <= crc_nx;
            end
            if (hold || rx_valid) tmo_cnt <= '0;
            else if (!ev_tmo)     tmo_cnt <= tmo_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lhm_fault_latch.sv
module lhm_fault_latch
    import lhm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               ev_tmo,
    input  logic               ev_hello_bad,
    input  logic               ev_crc_bad,
    input  logic               ev_peer,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause,
    output logic               err_req,
    output logic               peer_seen
);
    logic [CAUSE_W-1:0] evs, first;
    logic               set_now;

    always_comb begin
        evs           = '0;
        evs[C_TMO]    = ev_tmo;
        evs[C_HELLO]  = ev_hello_bad;
        evs[C_CRC]    = ev_crc_bad;
        evs[C_PEER]   = ev_peer;
        first         = evs & (~evs + 1'b1);
        set_now       = !clr && !fault && (|evs);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault     <= 1'b0;
            cause     <= '0;
            err_req   <= 1'b0;
            peer_seen <= 1'b0;
        end else begin
            err_req   <= set_now;
            peer_seen <= ev_peer;
            if (clr) begin
                fault <= 1'b0;
                cause <= '0;
            end else if (set_now) begin
                fault <= 1'b1;
                cause <= first;
            end
        end
    end
endmodule

// File: rtl/lhm_link_monitor.sv
module lhm_link_monitor
    import lhm_pkg::*;
#(
    parameter int PKT_FLITS = 8,
    parameter int IDLE_W    = 16,
    parameter int TMO_W     = 20,
    parameter logic [63:0] HELLO_PAT = 64'hA5C3_5A3C_0FF0_F00F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDLE_W-1:0] cfg_idle,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              fault_clr,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [63:0]       up_data,
    output logic              lk_tx_valid,
    output logic [1:0]        lk_tx_kind,
    output logic [63:0]       lk_tx_word,
    input  logic              lk_rx_valid,
    input  logic [1:0]        lk_rx_kind,
    input  logic [63:0]       lk_rx_word,
    output logic              fault,
    output logic [3:0]        fault_cause,
    output logic              err_pkt_req,
    output logic              peer_err_seen
);
    lk_kind_e tx_kind;
    logic     ev_tmo, ev_hello_bad, ev_crc_bad, ev_peer;

    lhm_tx_fsm #(.PKT_FLITS(PKT_FLITS), .IDLE_W(IDLE_W), .HELLO_PAT(HELLO_PAT)) tx_i (
        .clk(clk), .rst_n(rst_n), .fault(fault), .cfg_idle(cfg_idle),
        .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
        .tx_valid(lk_tx_valid), .tx_kind(tx_kind), .tx_word(lk_tx_word)
    );
    assign lk_tx_kind = tx_kind;

    lhm_rx_fsm #(.PKT_FLITS(PKT_FLITS), .TMO_W(TMO_W), .HELLO_PAT(HELLO_PAT)) rx_i (
        .clk(clk), .rst_n(rst_n), .hold(fault), .cfg_timeout(cfg_timeout),
        .rx_valid(lk_rx_valid), .rx_kind(lk_kind_e'(lk_rx_kind)), .rx_word(lk_rx_word),
        .ev_tmo(ev_tmo), .ev_hello_bad(ev_hello_bad), .ev_crc_bad(ev_crc_bad), .ev_peer(ev_peer)
    );

    lhm_fault_latch flt_i (
        .clk(clk), .rst_n(rst_n), .clr(fault_clr),
        .ev_tmo(ev_tmo), .ev_hello_bad(ev_hello_bad), .ev_crc_bad(ev_crc_bad), .ev_peer(ev_peer),
        .fault(fault), .cause(fault_cause), .err_req(err_pkt_req), .peer_seen(peer_err_seen)
    );
endmodule

// File: rtl/lhm_link_monitor_chk.sv
module lhm_link_monitor_chk #(
    parameter logic [63:0] HELLO_PAT = 64'hA5C3_5A3C_0FF0_F00F
) (
    input logic        clk,
    input logic        rst_n,
    input logic        fault_clr,
    input logic        up_ready,
    input logic        lk_tx_valid,
    input logic [1:0]  lk_tx_kind,
    input logic [63:0] lk_tx_word,
    input logic        fault,
    input logic [3:0]  fault_cause,
    input logic        err_pkt_req,
    input logic        peer_err_seen
);
    AST_READY_LOW_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !up_ready);                                                    // R11
    AST_LINK_QUIET_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && $past(fault)) |-> !lk_tx_valid);                               // R11
    AST_CAUSE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $countones(fault_cause) == 1);                                 // R10
    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && $past(fault) && !$past(fault_clr)) |-> $stable(fault_cause));  // R10
    AST_ERR_REQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pkt_req |-> (fault && !$past(fault)));                               // R10
    AST_PEER_SETS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_err_seen && !$past(fault_clr)) |-> fault);                         // R9
    AST_HELLO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_tx_valid && lk_tx_kind == 2'd2) |-> lk_tx_word == HELLO_PAT);        // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault_clr) |-> (!fault && fault_cause == 4'd0));                   // R12
endmodule

bind lhm_link_monitor lhm_link_monitor_chk #(.HELLO_PAT(HELLO_PAT)) chk_i (
    .clk(clk), .rst_n(rst_n), .fault_clr(fault_clr), .up_ready(up_ready),
    .lk_tx_valid(lk_tx_valid), .lk_tx_kind(lk_tx_kind), .lk_tx_word(lk_tx_word),
    .fault(fault), .fault_cause(fault_cause), .err_pkt_req(err_pkt_req),
    .peer_err_seen(peer_err_seen)
);

// File: tb/lhm_link_monitor_tb_top.sv
module lhm_link_monitor_tb_top;
    localparam int          NFL   = 8;
    localparam int          IDLE  = 20;
    localparam int          TMO   = 60;
    localparam logic [63:0] PAT   = 64'hA5C3_5A3C_0FF0_F00F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_clr = 1'b0;
    logic        up_valid = 1'b0;
    logic [63:0] up_data = '0;
    logic        up_ready, lk_tx_valid, fault, err_pkt_req, peer_err_seen;
    logic [1:0]  lk_tx_kind;
    logic [63:0] lk_tx_word;
    logic [3:0]  fault_cause;
    logic        ovr = 1'b0, ovr_valid = 1'b0;
    logic [1:0]  ovr_kind = 2'd0;
    logic [63:0] ovr_word = '0;
    logic        lk_rx_valid;
    logic [1:0]  lk_rx_kind;
    logic [63:0] lk_rx_word;

    assign lk_rx_valid = ovr ? ovr_valid : lk_tx_valid;
    assign lk_rx_kind  = ovr ? ovr_kind  : lk_tx_kind;
    assign lk_rx_word  = ovr ? ovr_word  : lk_tx_word;

    always #4 clk = ~clk;

    lhm_link_monitor #(.PKT_FLITS(NFL), .IDLE_W(16), .TMO_W(20), .HELLO_PAT(PAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_idle(16'(IDLE)), .cfg_timeout(20'(TMO)),
        .fault_clr(fault_clr), .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
        .lk_tx_valid(lk_tx_valid), .lk_tx_kind(lk_tx_kind), .lk_tx_word(lk_tx_word),
        .lk_rx_valid(lk_rx_valid), .lk_rx_kind(lk_rx_kind), .lk_rx_word(lk_rx_word),
        .fault(fault), .fault_cause(fault_cause), .err_pkt_req(err_pkt_req),
        .peer_err_seen(peer_err_seen)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    typedef struct { logic [1:0] k; logic [63:0] w; } item_t;
    item_t exp_q[$];
    int    cyc = 0, last_word = -1, tx_words = 0, err_pulses = 0;
    bit    want_data = 0;
    event  hello_ev;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [63:0] d);
        for (int b = 7; b >= 0; b--) begin
            c = c ^ {d[8*b +: 8], 8'h00};
            for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    always @(posedge clk) cyc++;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (err_pkt_req) err_pulses++;
        if (fault) last_word = -1;
        if (rst_n && lk_tx_valid) begin
            tx_words++;
            if (lk_tx_kind == 2'd2) begin
                chk(lk_tx_word == PAT, "R4 hello word", lk_tx_word, PAT);
                if (last_word >= 0)
                    chk(cyc - last_word == IDLE + 1, "R4 hello spacing", 64'(cyc - last_word), 64'(IDLE + 1));
                chk(!want_data, "R5 hello before raced packet", 64'd2, 64'd0);
                last_word = cyc;
                -> hello_ev;
            end else if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected link word", {62'd0, lk_tx_kind}, 64'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(lk_tx_kind == e.k && lk_tx_word == e.w,
                    (e.k == 2'd1) ? "R3 trailer" : "R2 data flit", lk_tx_word, e.w);
                want_data = 0;
                last_word = (e.k == 2'd1) ? cyc : -1;
            end
        end
    end

    // driver: caller is at a negedge
    task automatic send_pkt(input logic [63:0] base);
        logic [15:0] c = 16'hFFFF;
        item_t it;
        for (int i = 0; i < NFL; i++) begin
            up_valid = 1'b1;
            up_data  = base + 64'(i) * 64'h0101_0101_0101_0101;
            c        = ref_crc(c, up_data);
            it.k = 2'd0; it.w = up_data; exp_q.push_back(it);
            forever begin
                if (up_ready) begin @(negedge clk); break; end
                @(negedge clk);
            end
        end
        up_valid = 1'b0;
        it.k = 2'd1; it.w = {48'd0, c}; exp_q.push_back(it);
    endtask

    task automatic inj(input logic [1:0] k, input logic [63:0] w);
        ovr_valid = 1'b1; ovr_kind = k; ovr_word = w;
        @(negedge clk);
        ovr_valid = 1'b0;
    endtask

    task automatic clear_fault();
        ovr = 1'b0;
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk(!fault && fault_cause == 4'd0, "R12 clear", {59'd0, fault, fault_cause}, 64'd0);
        @(negedge clk);
        chk(up_ready, "R12 ready back", 64'(up_ready), 64'd1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        int w0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fault && fault_cause == 0 && !lk_tx_valid && up_ready, "R1 reset state",
            {58'd0, fault, fault_cause, lk_tx_valid}, 64'd0);

        send_pkt(64'h1122_3344_5566_7788);
        send_pkt(64'hFFFF_0000_DEAD_BEEF);
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R2 packets drained", 64'(exp_q.size()), 64'd0);

        repeat (100) @(negedge clk);
        chk(!fault, "R6 no false timeout", 64'(fault), 64'd0);

        // hello/data race on the expiry edge
        @(hello_ev);
        repeat (IDLE - 1) @(negedge clk);
        want_data = 1;
        send_pkt(64'h0F0F_0F0F_F0F0_F0F0);
        repeat (12) @(negedge clk);
        chk(!want_data && exp_q.size() == 0, "R5 data wins race", 64'(want_data), 64'd0);

        // receive timeout
        @(hello_ev);
        @(negedge clk);
        ovr = 1'b1; ovr_valid = 1'b0;
        w0 = err_pulses;
        repeat (TMO - 1) @(negedge clk);
        chk(!fault, "R6 not early", 64'(fault), 64'd0);
        @(negedge clk);
        chk(fault && fault_cause == 4'b0001 && err_pkt_req, "R6 timeout cause",
            {59'd0, err_pkt_req, fault_cause}, 64'h11);
        @(negedge clk);
        chk(err_pulses - w0 == 1, "R10 single err request", 64'(err_pulses - w0), 64'd1);

        // shut channel
        w0 = tx_words;
        up_valid = 1'b1; up_data = 64'h55;
        for (int i = 0; i < 30; i++) begin
            if (up_ready) chk(0, "R11 ready in fault", 64'd1, 64'd0);
            @(negedge clk);
        end
        up_valid = 1'b0;
        chk(tx_words == w0, "R11 link quiet", 64'(tx_words - w0), 64'd0);
        inj(2'd2, PAT ^ 64'd1);
        chk(fault_cause == 4'b0001, "R10 first cause held", 64'(fault_cause), 64'd1);
        clear_fault();

        // bad hello
        ovr = 1'b1;
        inj(2'd2, PAT ^ 64'h8000);
        chk(fault && fault_cause == 4'b0010 && err_pkt_req, "R7 hello mismatch",
            {59'd0, err_pkt_req, fault_cause}, 64'h12);
        clear_fault();

        // good injected packet, then corrupted one
        ovr = 1'b1;
        c = 16'hFFFF;
        for (int i = 0; i < NFL; i++) begin
            c = ref_crc(c, 64'hABCD_0000 + 64'(i));
            inj(2'd0, 64'hABCD_0000 + 64'(i));
        end
        inj(2'd1, {48'd0, c});
        chk(!fault, "R3 good packet accepted", 64'(fault), 64'd0);
        for (int i = 0; i < NFL; i++) inj(2'd0, 64'h77 + 64'(i));
        inj(2'd1, {48'd0, c});
        chk(fault && fault_cause == 4'b0100, "R8 crc mismatch", 64'(fault_cause), 64'h4);
        inj(2'd2, PAT ^ 64'd2);
        chk(fault_cause == 4'b0100, "R10 cause not overwritten", 64'(fault_cause), 64'h4);
        clear_fault();

        // early trailer
        ovr = 1'b1;
        for (int i = 0; i < 3; i++) inj(2'd0, 64'(i));
        inj(2'd1, 64'd0);
        chk(fault && fault_cause == 4'b0100, "R8 early trailer", 64'(fault_cause), 64'h4);
        clear_fault();

        // peer error notification
        ovr = 1'b1;
        inj(2'd3, 64'd0);
        chk(peer_err_seen && fault && fault_cause == 4'b1000, "R9 peer error",
            {59'd0, peer_err_seen, fault_cause}, 64'h18);
        @(negedge clk);
        chk(!peer_err_seen, "R9 pulse width", 64'(peer_err_seen), 64'd0);
        clear_fault();

        send_pkt(64'h0123_4567_89AB_CDEF);
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0 && !fault, "R2 resumed after clear", 64'(exp_q.size()), 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule